// File: doc/BRIEF.md
# Center-Aligned Up-Down PWM Generator

This block produces a symmetric (center-aligned) pulse-width-modulated waveform. A 16-bit time-base counter climbs from zero to the period value and falls back to zero, so one output period spans twice the period value in counter ticks. The counter does not advance on every system clock. It advances on a tick enable that comes from two chained 3-bit dividers. One divider uses power-of-two codes and the other uses even-multiple codes.

The waveform can be routed to output A, output B, both, or neither. Its active level is selectable, and a separate idle level is driven whenever the generator is stopped or forced idle. Period and compare values are written into shadow registers. They take effect at the end of the running period, so the output never produces a short or glitched period. A notification pulse, one clock wide, marks the end of every period when it is enabled.

Divider codes, levels, routing and the notification enable are written only while the generator is stopped. A start command loads the shadow values and restarts the counter from zero.

Top module: `updown_pwm`

## Requirements
- R1: After reset, `pwm_a`, `pwm_b` and `notify` are low and the generator is stopped, with idle level low, active level high, routing to A only and notification off.
- R2: With period value P > 0 and tick divider D, the output period, and the spacing between notification pulses, is 2·P·D system clocks.
- R3: With compare value C, the output is active for 2·C ticks of each period when 0 < C < P. C = 0 gives an output that is never active. C ≥ P gives an output that is always active.
- R4: D equals the high-speed factor times the clock factor. The clock-divider code n gives 2^n. The high-speed code 0 gives 1, and a code n from 1 to 7 gives 2·n.
- R5: Output select code 2'b01 drives A, 2'b10 drives B and 2'b11 drives both with identical waveforms. An output that is not selected holds the idle level.
- R6: Active-level bit 1 drives the active portion high. Active-level bit 0 drives it low.
- R7: A force-idle strobe stops the generator. Both outputs show the idle level on the second clock after the strobe and keep it until a start strobe, with no notification in between.
- R8: Period and compare writes made during a period do not change that period. They take effect from the next period on.
- R9: A configuration write (dividers, levels, routing, notification enable) while the generator runs is ignored.
- R10: When notification is enabled, exactly one pulse, one clock wide, appears per period. When it is disabled, none appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe (accepted only when stopped) |
| cfg_clkdiv | input | 3 | Power-of-two divider code |
| cfg_hsdiv | input | 3 | Even-multiple divider code |
| cfg_act_high | input | 1 | 1: active portion driven high |
| cfg_idle_high | input | 1 | Idle level |
| cfg_out_sel | input | 2 | Output routing code |
| cfg_notify_en | input | 1 | Notification enable |
| prd_wr | input | 1 | Period shadow write strobe |
| prd_data | input | 16 | Period value |
| cmp_wr | input | 1 | Compare shadow write strobe |
| cmp_data | input | 16 | Compare value |
| start | input | 1 | Load shadows, restart counter, run |
| force_idle | input | 1 | Stop and drive idle level (wins over start) |
| pwm_a | output | 1 | Waveform output A |
| pwm_b | output | 1 | Waveform output B |
| notify | output | 1 | One-clock end-of-period pulse |

## Verification
A counter that overshoots the period, or a divider that decodes a code wrongly, shows up at once as a wrong spacing between notification pulses, within the first period. A shadow value copied at the wrong moment shortens or stretches the period in which the write landed, so the bench times the interval around such a write. A wrong compare decision or a wrong level choice changes the count of active clocks over any whole number of periods, so the bench counts active clocks over windows aligned to notification pulses.

// File: rtl/updown_pwm_pkg.sv
package updown_pwm_pkg;

    localparam int CODE_W  = 3;
    localparam int MAX_DIV = 2 * ((1 << CODE_W) - 1) * (1 << ((1 << CODE_W) - 1));
    localparam int DIV_W   = $clog2(MAX_DIV + 1);

    typedef enum logic [1:0] {
        SEL_NONE = 2'b00,
        SEL_A    = 2'b01,
        SEL_B    = 2'b10,
        SEL_AB   = 2'b11
    } out_sel_e;

    typedef struct packed {
        logic [CODE_W-1:0] clkdiv;
        logic [CODE_W-1:0] hsdiv;
        logic              act_high;
        logic              idle_high;
        out_sel_e          sel;
        logic              notif_en;
    } pwm_cfg_t;

    localparam pwm_cfg_t CFG_RESET = '{clkdiv: '0, hsdiv: '0, act_high: 1'b1,
                                       idle_high: 1'b0, sel: SEL_A, notif_en: 1'b0};

    // total ticks divider: even-multiple stage times power-of-two stage
    function automatic logic [DIV_W-1:0] div_factor(input logic [CODE_W-1:0] hs,
                                                    input logic [CODE_W-1:0] cd);
        int unsigned hsf;
        hsf = (hs == '0) ? 1 : 2 * int'(hs);
        return DIV_W'(hsf << cd);
    endfunction

endpackage

// File: rtl/updown_pwm_prescaler.sv
module updown_pwm_prescaler
    import updown_pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run_i,
    input  logic              restart_i,
    input  logic [CODE_W-1:0] hs_i,
    input  logic [CODE_W-1:0] cd_i,
    output logic              tick_o
);
    logic [DIV_W-1:0] pcnt_q;
    logic [DIV_W-1:0] div_w;

    assign div_w  = div_factor(hs_i, cd_i);
    assign tick_o = run_i && !restart_i && (pcnt_q == div_w - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run_i || restart_i) begin
            pcnt_q <= '0;
        end else if (tick_o) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/updown_pwm_timebase.sv
module updown_pwm_timebase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             prd_wr_i,
    input  logic [CNT_W-1:0] prd_data_i,
    input  logic             cmp_wr_i,
    input  logic [CNT_W-1:0] cmp_data_i,
    input  logic             restart_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] act_prd_o,
    output logic             active_o,
    output logic             period_end_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] sh_prd_q, sh_cmp_q, act_prd_q, act_cmp_q, cnt_q;
    logic             up_q;
    logic             reload_w;

    assign period_end_o = tick_i && !up_q && (cnt_q == ONE);
    assign reload_w     = period_end_o || (tick_i && (act_prd_q == '0));
    assign active_o     = up_q ? (cnt_q < act_cmp_q) : (cnt_q <= act_cmp_q);
    assign cnt_o        = cnt_q;
    assign act_prd_o    = act_prd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_prd_q  <= '0;
            sh_cmp_q  <= '0;
            act_prd_q <= '0;
            act_cmp_q <= '0;
            cnt_q     <= '0;
            up_q      <= 1'b1;
        end else begin
            if (prd_wr_i) sh_prd_q <= prd_data_i;
            if (cmp_wr_i) sh_cmp_q <= cmp_data_i;
            if (restart_i) begin
                act_prd_q <= sh_prd_q;
                act_cmp_q <= sh_cmp_q;
                cnt_q     <= '0;
                up_q      <= 1'b1;
            end else if (tick_i) begin
                if (reload_w) begin
                    act_prd_q <= sh_prd_q;
                    act_cmp_q <= sh_cmp_q;
                end
                if (act_prd_q == '0) begin
                    cnt_q <= '0;
                    up_q  <= 1'b1;
                end else if (up_q) begin
                    cnt_q <= cnt_q + ONE;
                    if (cnt_q + ONE == act_prd_q) up_q <= 1'b0;
                end else begin
                    cnt_q <= cnt_q - ONE;
                    if (cnt_q == ONE) up_q <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/updown_pwm_outstage.sv
module updown_pwm_outstage
    import updown_pwm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     run_i,
    input  pwm_cfg_t cfg_i,
    input  logic     active_i,
    input  logic     period_end_i,
    output logic     pwm_a_o,
    output logic     pwm_b_o,
    output logic     notify_o
);
    logic [1:0] sel_bits;
    logic [1:0] out_q;
    logic       level_w;
    logic       notify_q;

    assign sel_bits = cfg_i.sel;
    assign level_w  = cfg_i.act_high ? active_i : !active_i;

    for (genvar k = 0; k < 2; k++) begin : g_out
        always_ff @(posedge clk) begin
            if (rst) begin
                out_q[k] <= 1'b0;
            end else begin
                out_q[k] <= (run_i && sel_bits[k]) ? level_w : cfg_i.idle_high;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) notify_q <= 1'b0;
        else     notify_q <= period_end_i && cfg_i.notif_en;
    end

    assign pwm_a_o  = out_q[0];
    assign pwm_b_o  = out_q[1];
    assign notify_o = notify_q;
endmodule

// File: rtl/updown_pwm.sv
module updown_pwm
    import updown_pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [CODE_W-1:0] cfg_clkdiv,
    input  logic [CODE_W-1:0] cfg_hsdiv,
    input  logic              cfg_act_high,
    input  logic              cfg_idle_high,
    input  logic [1:0]        cfg_out_sel,
    input  logic              cfg_notify_en,
    input  logic              prd_wr,
    input  logic [CNT_W-1:0]  prd_data,
    input  logic              cmp_wr,
    input  logic [CNT_W-1:0]  cmp_data,
    input  logic              start,
    input  logic              force_idle,
    output logic              pwm_a,
    output logic              pwm_b,
    output logic              notify
);
    pwm_cfg_t         cfg_q;
    logic             run_q;
    logic             restart_w;
    logic             tick_w;
    logic             active_w;
    logic             period_end_w;
    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] act_prd_w;

    assign restart_w = start && !force_idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            cfg_q <= CFG_RESET;
        end else begin
            if (force_idle)     run_q <= 1'b0;
            else if (restart_w) run_q <= 1'b1;
            if (cfg_wr && !run_q) begin
                cfg_q.clkdiv    <= cfg_clkdiv;
                cfg_q.hsdiv     <= cfg_hsdiv;
                cfg_q.act_high  <= cfg_act_high;
                cfg_q.idle_high <= cfg_idle_high;
                cfg_q.sel       <= out_sel_e'(cfg_out_sel);
                cfg_q.notif_en  <= cfg_notify_en;
            end
        end
    end

    updown_pwm_prescaler u_presc (
        .clk       (clk),
        .rst       (rst),
        .run_i     (run_q),
        .restart_i (restart_w),
        .hs_i      (cfg_q.hsdiv),
        .cd_i      (cfg_q.clkdiv),
        .tick_o    (tick_w)
    );

    updown_pwm_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk          (clk),
        .rst          (rst),
        .prd_wr_i     (prd_wr),
        .prd_data_i   (prd_data),
        .cmp_wr_i     (cmp_wr),
        .cmp_data_i   (cmp_data),
        .restart_i    (restart_w),
        .tick_i       (tick_w),
        .cnt_o        (cnt_w),
        .act_prd_o    (act_prd_w),
        .active_o     (active_w),
        .period_end_o (period_end_w)
    );

    updown_pwm_outstage u_out (
        .clk          (clk),
        .rst          (rst),
        .run_i        (run_q),
        .cfg_i        (cfg_q),
        .active_i     (active_w),
        .period_end_i (period_end_w),
        .pwm_a_o      (pwm_a),
        .pwm_b_o      (pwm_b),
        .notify_o     (notify)
    );
endmodule

// File: rtl/updown_pwm_chk.sv
module updown_pwm_chk
    import updown_pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             run_i,
    input pwm_cfg_t         cfg_i,
    input logic [CNT_W-1:0] cnt_i,
    input logic [CNT_W-1:0] act_prd_i,
    input logic             pwm_a_i,
    input logic             pwm_b_i,
    input logic             notify_i
);
    // R7: a stopped generator shows the idle level on both outputs one clock later
    p_idle_level_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(run_i)) |->
            (pwm_a_i == $past(cfg_i.idle_high) && pwm_b_i == $past(cfg_i.idle_high)));

    // R2: the counter never climbs past the active period value
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
        run_i |-> (cnt_i <= act_prd_i));

    // R8: the active period changes only when the counter sits at zero
    p_reload_at_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (run_i && $past(run_i) && !$past(rst) && !$stable(act_prd_i)) |-> (cnt_i == '0));

    // R9: configuration stays fixed while running
    p_cfg_locked_r9: assert property (@(posedge clk) disable iff (rst)
        (run_i && $past(run_i) && !$past(rst)) |-> $stable(cfg_i));

    // R10: notification is a single-clock pulse
    p_notify_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        notify_i |=> !notify_i);
endmodule

bind updown_pwm updown_pwm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .run_i     (run_q),
    .cfg_i     (cfg_q),
    .cnt_i     (cnt_w),
    .act_prd_i (act_prd_w),
    .pwm_a_i   (pwm_a),
    .pwm_b_i   (pwm_b),
    .notify_i  (notify)
);

// File: tb/updown_pwm_tb.sv
module updown_pwm_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_clkdiv = '0;
    logic [2:0]  cfg_hsdiv = '0;
    logic        cfg_act_high = 1'b1;
    logic        cfg_idle_high = 1'b0;
    logic [1:0]  cfg_out_sel = 2'b01;
    logic        cfg_notify_en = 1'b0;
    logic        prd_wr = 1'b0;
    logic [15:0] prd_data = '0;
    logic        cmp_wr = 1'b0;
    logic [15:0] cmp_data = '0;
    logic        start = 1'b0;
    logic        force_idle = 1'b0;
    logic        pwm_a, pwm_b, notify;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    updown_pwm u_dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_clkdiv(cfg_clkdiv),
        .cfg_hsdiv(cfg_hsdiv), .cfg_act_high(cfg_act_high),
        .cfg_idle_high(cfg_idle_high), .cfg_out_sel(cfg_out_sel),
        .cfg_notify_en(cfg_notify_en), .prd_wr(prd_wr), .prd_data(prd_data),
        .cmp_wr(cmp_wr), .cmp_data(cmp_data), .start(start),
        .force_idle(force_idle), .pwm_a(pwm_a), .pwm_b(pwm_b), .notify(notify)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_note(output int cyc);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!notify && cyc < 5000);
    endtask

    task automatic count_window(input int n, output int a, output int b, output int notes);
        a = 0; b = 0; notes = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            a += int'(pwm_a);
            b += int'(pwm_b);
            notes += int'(notify);
        end
    endtask

    task automatic setup(input logic [2:0] cd, input logic [2:0] hs, input logic ah,
                         input logic ih, input logic [1:0] sel, input logic ne,
                         input int prd, input int cmp);
        @(negedge clk); force_idle = 1'b1;
        @(negedge clk); force_idle = 1'b0;
        cfg_wr = 1'b1; cfg_clkdiv = cd; cfg_hsdiv = hs; cfg_act_high = ah;
        cfg_idle_high = ih; cfg_out_sel = sel; cfg_notify_en = ne;
        @(negedge clk); cfg_wr = 1'b0;
        prd_wr = 1'b1; prd_data = 16'(prd); cmp_wr = 1'b1; cmp_data = 16'(cmp);
        @(negedge clk); prd_wr = 1'b0; cmp_wr = 1'b0;
        start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    // align to a period boundary, check the spacing, then count over three periods
    task automatic measure(input string req, input int per, input int exp_a, input int exp_b);
        int c, a, b, n;
        wait_note(c);
        wait_note(c);
        check({req, " period"}, c, per);
        count_window(3 * per, a, b, n);
        check({req, " active A"}, a, 3 * exp_a);
        check({req, " active B"}, b, 3 * exp_b);
        check({req, " R10 notes"}, n, 3);
    endtask

    task automatic t_reset;
        int a, b, n;
        @(negedge clk);
        check("R1 pwm_a", int'(pwm_a), 0);
        check("R1 notify", int'(notify), 0);
        count_window(50, a, b, n);
        check("R1 stopped A", a, 0);
        check("R1 stopped B", b, 0);
        check("R1 stopped notes", n, 0);
    endtask

    task automatic t_basic;
        // R2 R3 R5: D=1, P=10, C=3 on both outputs
        setup(3'd0, 3'd0, 1'b1, 1'b0, 2'b11, 1'b1, 10, 3);
        measure("R2 R3 R5 basic", 20, 6, 6);
    endtask

    task automatic t_presc;
        // R4: hs code 2 (x4) * cd code 1 (x2) = 8; P=5, C=2
        setup(3'd1, 3'd2, 1'b1, 1'b0, 2'b01, 1'b1, 5, 2);
        measure("R4 div8", 80, 32, 0);
        // R4: hs code 3 (x6), cd code 0; P=4, C=1
        setup(3'd0, 3'd3, 1'b1, 1'b0, 2'b01, 1'b1, 4, 1);
        measure("R4 div6", 48, 12, 0);
        // R4: hs code 0 (x1), cd code 3 (x8); P=2, C=1
        setup(3'd3, 3'd0, 1'b1, 1'b0, 2'b01, 1'b1, 2, 1);
        measure("R4 div8pow", 32, 16, 0);
    endtask

    task automatic t_duty_edges;
        setup(3'd0, 3'd0, 1'b1, 1'b0, 2'b01, 1'b1, 10, 0);
        measure("R3 zero duty", 20, 0, 0);
        setup(3'd0, 3'd0, 1'b1, 1'b0, 2'b01, 1'b1, 10, 10);
        measure("R3 cmp eq prd", 20, 20, 0);
        setup(3'd0, 3'd0, 1'b1, 1'b0, 2'b01, 1'b1, 10, 40);
        measure("R3 cmp above prd", 20, 20, 0);
    endtask

    task automatic t_polarity;
        setup(3'd0, 3'd0, 1'b0, 1'b0, 2'b01, 1'b1, 10, 3);
        measure("R6 active low", 20, 14, 0);
    endtask

    task automatic t_select;
        // R5: B only, idle level high, so A holds high all the time
        setup(3'd0, 3'd0, 1'b1, 1'b1, 2'b10, 1'b1, 10, 3);
        measure("R5 B only", 20, 20, 6);
    endtask

    task automatic t_idle;
        int a, b, n, c;
        setup(3'd0, 3'd0, 1'b1, 1'b1, 2'b11, 1'b1, 10, 3);
        wait_note(c);
        @(negedge clk); force_idle = 1'b1;
        @(negedge clk); force_idle = 1'b0;
        @(negedge clk);
        check("R7 A idle", int'(pwm_a), 1);
        check("R7 B idle", int'(pwm_b), 1);
        count_window(100, a, b, n);
        check("R7 A held", a, 100);
        check("R7 B held", b, 100);
        check("R7 no notes", n, 0);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_note(c);
        wait_note(c);
        check("R7 restart period", c, 20);
    endtask

    task automatic t_shadow;
        int c, c2, a, b, n;
        setup(3'd0, 3'd0, 1'b1, 1'b0, 2'b01, 1'b1, 10, 3);
        wait_note(c);
        repeat (5) @(negedge clk);
        prd_wr = 1'b1; prd_data = 16'd6; cmp_wr = 1'b1; cmp_data = 16'd2;
        @(negedge clk); prd_wr = 1'b0; cmp_wr = 1'b0;
        wait_note(c2);
        check("R8 old period kept", 6 + c2, 20);
        wait_note(c);
        check("R8 new period", c, 12);
        count_window(36, a, b, n);
        check("R8 new duty", a, 12);
    endtask

    task automatic t_cfg_locked;
        int c, a, b, n;
        setup(3'd0, 3'd0, 1'b1, 1'b0, 2'b01, 1'b1, 10, 3);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_clkdiv = 3'd7; cfg_hsdiv = 3'd7; cfg_out_sel = 2'b00;
        cfg_act_high = 1'b0; cfg_notify_en = 1'b0;
        @(negedge clk); cfg_wr = 1'b0;
        wait_note(c);
        wait_note(c);
        check("R9 period unchanged", c, 20);
        count_window(60, a, b, n);
        check("R9 duty unchanged", a, 18);
        check("R9 notes unchanged", n, 3);
    endtask

    task automatic t_notify_off;
        int a, b, n;
        setup(3'd0, 3'd0, 1'b1, 1'b0, 2'b01, 1'b0, 10, 3);
        count_window(200, a, b, n);
        check("R10 disabled notes", n, 0);
        check("R10 output still runs", a, 60);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_presc();
        t_duty_edges();
        t_polarity();
        t_select();
        t_idle();
        t_shadow();
        t_cfg_locked();
        t_notify_off();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule